// File: doc/BRIEF.md
# Double-Buffered Audio Frame Packer

This block gathers 24-bit signed audio samples into a two-bank sample store and turns every group of 84 samples into one raw Ethernet II frame. Samples arrive on a simple valid-qualified input, one per cycle at most, and are written into the bank currently being filled. When that bank holds its 84th sample, the block hands it to the frame streamer and capture moves on into the other bank, so recording never stops while a frame is sent.

The frame leaves one byte per handshake on a ready/valid byte stream that carries start-of-frame and end-of-frame markers. Each frame is a fixed 14-byte header followed by 252 payload bytes, with every sample sent most significant byte first. The header is a broadcast destination (all ones), an all-zero source address and a zero EtherType. The frame check sequence is left to the downstream MAC. The two banks are the two halves of one memory, and the bank is chosen by the top address bit.

If a bank fills again while the previous frame is still being sent, a sticky overrun flag is raised. The newly completed group is dropped, and capture starts again at the beginning of the same bank. The frame already in flight is not disturbed.

Top module: `audio_frame_packer`

## Requirements
- R1: While reset is high and in the first cycle after it, `tx_valid` and `overrun` are 0.
- R2: A frame is exactly 266 accepted bytes. `tx_sof` is high only with the first byte and `tx_eof` only with the last, and the two are never high together.
- R3: Header bytes 0 to 5 are 0xFF (destination). Bytes 6 to 11 are 0x00 (source) and bytes 12 to 13 are 0x00 (EtherType).
- R4: Payload byte 14+3k+j carries sample k of the group. j=0 is bits 23:16, j=1 is bits 15:8 and j=2 is bits 7:0 (big-endian).
- R5: One frame is released for each 84 accepted samples. Frames go out in the order their groups were captured, and each carries the samples of its group in arrival order.
- R6: Samples that arrive while a frame is being sent are stored in the other bank and appear intact in the next frame.
- R7: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data`, `tx_sof` and `tx_eof` hold their values.
- R8: If an 84-sample group completes before the previous frame's last byte has been accepted, `overrun` goes to 1 and stays there until reset. That group is not sent, and the frame in flight continues unaltered.
- R9: After an overrun, capture restarts at sample 0 of the same bank, so the next full group is sent normally.
- R10: Input data in cycles where `smp_valid` is 0 is not stored and has no effect on any frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample present this cycle |
| smp_data | input | 24 | Signed PCM sample |
| tx_ready | input | 1 | Downstream accepts the current byte |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Frame byte |
| tx_sof | output | 1 | First byte of frame |
| tx_eof | output | 1 | Last byte of frame |
| overrun | output | 1 | Sticky: a group completed while a frame was still being sent |

## Verification
The assertions check on every cycle that the output holds under backpressure, that start and end markers are well formed, that a start byte is 0xFF, that every frame ends on its 266th accepted byte, and that the overrun flag never clears. Only the bench scenarios can show that payload bytes match the samples in big-endian order, that groups captured during transmission land in the next frame, that an overrun drops exactly the colliding group while the held frame survives, and that junk data on idle input cycles never reaches a frame.

// File: rtl/afp_pkg.sv
package afp_pkg;
  localparam int HDR_BYTES = 14;
  localparam logic [47:0] DST_ADDR = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] SRC_ADDR = 48'h0000_0000_0000;
  localparam logic [15:0] ETH_TYPE = 16'h0000;
  localparam logic [8*HDR_BYTES-1:0] HDR_VEC = {DST_ADDR, SRC_ADDR, ETH_TYPE};

  // Header byte at frame position p (0 = first on the wire).
  function automatic logic [7:0] hdr_byte(input int unsigned p);
    if (p >= HDR_BYTES) return 8'h00;
    return HDR_VEC[8*(HDR_BYTES-1-p) +: 8];
  endfunction
endpackage

// File: rtl/afp_bank_ram.sv
module afp_bank_ram #(
  parameter int WIDTH  = 24,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WIDTH-1:0]  rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/afp_capture.sv
module afp_capture #(
  parameter int SAMPLE_W = 24,
  parameter int SAMPLES  = 84,
  parameter int IDX_W    = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic                rdr_idle,
  output logic                we,
  output logic [IDX_W:0]      waddr,
  output logic [SAMPLE_W-1:0] wdata,
  output logic                launch,
  output logic                launch_bank,
  output logic                overrun
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SAMPLES - 1);

  logic [IDX_W-1:0] idx;
  logic             bank;
  logic             group_done;

  assign we          = smp_valid;
  assign waddr       = {bank, idx};
  assign wdata       = smp_data;
  assign group_done  = smp_valid && (idx == LAST_IDX);
  assign launch      = group_done && rdr_idle;
  assign launch_bank = bank;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx     <= '0;
      bank    <= 1'b0;
      overrun <= 1'b0;
    end else if (smp_valid) begin
      if (idx == LAST_IDX) begin
        idx <= '0;
        if (rdr_idle) bank    <= ~bank;
        else          overrun <= 1'b1;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/afp_framer.sv
module afp_framer
  import afp_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SAMPLES  = 84,
  parameter int IDX_W    = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                launch,
  input  logic                launch_bank,
  input  logic [SAMPLE_W-1:0] rd_q,
  output logic [IDX_W:0]      rd_addr,
  output logic                idle,
  input  logic                tx_ready,
  output logic                tx_valid,
  output logic [7:0]          tx_data,
  output logic                tx_sof,
  output logic                tx_eof
);
  localparam int SAMPLE_BYTES = SAMPLE_W / 8;
  localparam int FRAME_BYTES  = HDR_BYTES + SAMPLES * SAMPLE_BYTES;
  localparam int POS_W        = $clog2(FRAME_BYTES);
  localparam int SB_W         = (SAMPLE_BYTES > 1) ? $clog2(SAMPLE_BYTES) : 1;
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BYTES - 1);
  localparam logic [POS_W-1:0] PAY_POS  = POS_W'(HDR_BYTES);
  localparam logic [SB_W-1:0]  LAST_SB  = SB_W'(SAMPLE_BYTES - 1);

  logic             active;
  logic             bank;
  logic [POS_W-1:0] pos;
  logic [IDX_W-1:0] ridx, ridx_n;
  logic [SB_W-1:0]  bsel;
  logic             adv, step, in_pay, sb_wrap;
  logic [7:0]       pay_byte, next_byte;

  assign adv     = !tx_valid || tx_ready;
  assign step    = adv && active;
  assign in_pay  = pos >= PAY_POS;
  assign sb_wrap = bsel == LAST_SB;
  assign idle    = !active && !tx_valid;

  // Address from the index the next cycle will use, so the registered read
  // data lines up with the sample being serialised.
  always_comb begin
    if (launch)                        ridx_n = '0;
    else if (step && in_pay && sb_wrap) ridx_n = ridx + 1'b1;
    else                               ridx_n = ridx;
  end
  assign rd_addr = {launch ? launch_bank : bank, ridx_n};

  assign pay_byte  = rd_q[SAMPLE_W-1-8*bsel -: 8];
  assign next_byte = in_pay ? pay_byte : hdr_byte(int'(pos));

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      bank     <= 1'b0;
      pos      <= '0;
      ridx     <= '0;
      bsel     <= '0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
      tx_sof   <= 1'b0;
      tx_eof   <= 1'b0;
    end else begin
      ridx <= ridx_n;
      if (launch) begin
        active <= 1'b1;
        bank   <= launch_bank;
        pos    <= '0;
        bsel   <= '0;
      end else if (step) begin
        pos <= pos + 1'b1;
        if (pos == LAST_POS) active <= 1'b0;
        if (in_pay) bsel <= sb_wrap ? '0 : bsel + 1'b1;
      end
      if (adv) begin
        tx_valid <= step;
        tx_data  <= step ? next_byte : 8'h00;
        tx_sof   <= step && (pos == '0);
        tx_eof   <= step && (pos == LAST_POS);
      end
    end
  end
endmodule

// File: rtl/audio_frame_packer.sv
module audio_frame_packer #(
  parameter int SAMPLE_W          = 24,
  parameter int SAMPLES_PER_FRAME = 84
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic                tx_ready,
  output logic                tx_valid,
  output logic [7:0]          tx_data,
  output logic                tx_sof,
  output logic                tx_eof,
  output logic                overrun
);
  localparam int IDX_W  = $clog2(SAMPLES_PER_FRAME);
  localparam int ADDR_W = IDX_W + 1;

  logic                we;
  logic [ADDR_W-1:0]   waddr, raddr;
  logic [SAMPLE_W-1:0] wdata, rdata;
  logic                launch, launch_bank, rdr_idle;

  afp_capture #(
    .SAMPLE_W(SAMPLE_W), .SAMPLES(SAMPLES_PER_FRAME), .IDX_W(IDX_W)
  ) u_capture (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .rdr_idle(rdr_idle), .we(we), .waddr(waddr), .wdata(wdata),
    .launch(launch), .launch_bank(launch_bank), .overrun(overrun)
  );

  afp_bank_ram #(.WIDTH(SAMPLE_W), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(rdata)
  );

  afp_framer #(
    .SAMPLE_W(SAMPLE_W), .SAMPLES(SAMPLES_PER_FRAME), .IDX_W(IDX_W)
  ) u_framer (
    .clk(clk), .rst(rst), .launch(launch), .launch_bank(launch_bank),
    .rd_q(rdata), .rd_addr(raddr), .idle(rdr_idle),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_sof(tx_sof), .tx_eof(tx_eof)
  );
endmodule

// File: rtl/afp_checker.sv
module afp_checker #(
  parameter int SAMPLE_W          = 24,
  parameter int SAMPLES_PER_FRAME = 84
) (
  input logic       clk,
  input logic       rst,
  input logic       tx_ready,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       tx_sof,
  input logic       tx_eof,
  input logic       overrun
);
  localparam int FRAME_BYTES = 14 + SAMPLES_PER_FRAME * (SAMPLE_W / 8);
  localparam int CNT_W       = $clog2(FRAME_BYTES) + 1;

  logic [CNT_W-1:0] acc_cnt;
  always_ff @(posedge clk) begin
    if (rst) acc_cnt <= '0;
    else if (tx_valid && tx_ready) acc_cnt <= tx_sof ? CNT_W'(1) : acc_cnt + 1'b1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> !tx_valid && !overrun);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_sof) && $stable(tx_eof));

  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  // R2
  sof_form_chk: assert property (@(posedge clk) disable iff (rst)
    tx_sof |-> tx_valid && !tx_eof);

  // R2
  eof_form_chk: assert property (@(posedge clk) disable iff (rst)
    tx_eof |-> tx_valid);

  // R3
  sof_header_chk: assert property (@(posedge clk) disable iff (rst)
    tx_sof |-> tx_data == 8'hFF);

  // R2
  frame_len_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid && tx_ready && tx_eof |-> acc_cnt == CNT_W'(FRAME_BYTES - 1));
endmodule

bind audio_frame_packer afp_checker #(
  .SAMPLE_W(SAMPLE_W), .SAMPLES_PER_FRAME(SAMPLES_PER_FRAME)
) u_chk (
  .clk(clk), .rst(rst), .tx_ready(tx_ready), .tx_valid(tx_valid),
  .tx_data(tx_data), .tx_sof(tx_sof), .tx_eof(tx_eof), .overrun(overrun)
);

// File: tb/audio_frame_packer_tb.sv
module audio_frame_packer_tb;
  localparam int N = 84;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [23:0] smp_data = '0;
  logic        tx_ready = 1'b0;
  logic        tx_valid, tx_sof, tx_eof, overrun;
  logic [7:0]  tx_data;

  audio_frame_packer u_dut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_sof(tx_sof), .tx_eof(tx_eof), .overrun(overrun)
  );

  always #2 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int ready_mode = 0;
  int frames_seen = 0;
  int mpos = 0;
  logic [9:0] exp_q[$];
  logic       prev_stall = 1'b0;
  logic [9:0] held;

  always @(posedge clk) cyc++;

  always begin
    @(posedge clk);
    #1;
    case (ready_mode)
      0: tx_ready = 1'b1;
      1: tx_ready = (cyc % 3) != 0;
      default: tx_ready = 1'b0;
    endcase
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] smp_val(input int g, input int k);
    if (k == 0) return 24'h800000;
    if (k == 1) return 24'h7FFFFF;
    return 24'((g * 40503 + k * 2654435) ^ 24'h5AA55A);
  endfunction

  // Driver: queue the expected frame, then feed the group.
  task automatic send_group(input int g, input int gap, input bit sent);
    if (sent) begin
      for (int i = 0; i < 14; i++)
        exp_q.push_back({i == 0, 1'b0, (i < 6) ? 8'hFF : 8'h00});
      for (int k = 0; k < N; k++) begin
        logic [23:0] s;
        s = smp_val(g, k);
        exp_q.push_back({2'b00, s[23:16]});
        exp_q.push_back({2'b00, s[15:8]});
        exp_q.push_back({1'b0, k == N - 1, s[7:0]});
      end
    end
    for (int k = 0; k < N; k++) begin
      @(posedge clk); #1;
      smp_valid = 1'b1;
      smp_data  = smp_val(g, k);
      for (int w = 1; w < gap; w++) begin
        @(posedge clk); #1;
        smp_valid = 1'b0;
        smp_data  = ~smp_val(g, k) ^ 24'h13579B;  // R10 junk on idle cycles
      end
    end
    @(posedge clk); #1;
    smp_valid = 1'b0;
  endtask

  task automatic wait_drain();
    int n = 0;
    while ((exp_q.size() != 0 || tx_valid) && n < 5000) begin
      @(posedge clk);
      n++;
    end
    #1;
  endtask

  // Monitor: compare accepted bytes, and hold stability under stall.
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall)
        check(tx_valid && {tx_sof, tx_eof, tx_data} == held, "R7", "stall hold",
              int'({tx_valid, tx_sof, tx_eof, tx_data}), int'({1'b1, held}));
      prev_stall = tx_valid && !tx_ready;
      held = {tx_sof, tx_eof, tx_data};
      if (tx_valid && tx_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R5", "unexpected byte", int'(tx_data), 0);
        end else begin
          logic [9:0] e;
          string req;
          e = exp_q.pop_front();
          if (e[9]) mpos = 0;
          req = (e[9] || e[8]) ? "R2" : (mpos < 14 ? "R3" : "R4");
          check({tx_sof, tx_eof, tx_data} == e, req, "frame byte",
                int'({tx_sof, tx_eof, tx_data}), int'(e));
          mpos++;
        end
        if (tx_eof) frames_seen++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int err_mark;
    repeat (4) @(posedge clk);
    #1;
    check(!tx_valid && !overrun, "R1", "reset state",
          int'({tx_valid, overrun}), 0);
    rst = 1'b0;

    ready_mode = 0;
    send_group(0, 4, 1'b1);               // R5 first frame
    send_group(1, 4, 1'b1);               // R6 captured during frame 0
    ready_mode = 1;
    send_group(2, 6, 1'b1);               // R7 throttled ready
    wait_drain();
    check(exp_q.size() == 0, "R6", "frames drained", exp_q.size(), 0);
    check(!overrun, "R6", "no overrun at safe rate", int'(overrun), 0);
    check(frames_seen == 3, "R5", "frames sent", frames_seen, 3);

    ready_mode = 2;
    send_group(3, 2, 1'b1);               // stalled frame
    send_group(4, 1, 1'b0);               // R8 collides, dropped
    check(overrun, "R8", "overrun raised", int'(overrun), 1);
    check(tx_valid && tx_sof && tx_data == 8'hFF, "R8", "held frame intact",
          int'({tx_valid, tx_sof, tx_data}), 'h3FF);

    err_mark = errors;
    ready_mode = 0;
    send_group(5, 4, 1'b1);               // R9 restart in same bank
    wait_drain();
    check(exp_q.size() == 0, "R9", "frame after overrun delivered", exp_q.size(), 0);
    check(errors == err_mark, "R10", "idle-cycle junk not stored", errors - err_mark, 0);
    check(frames_seen == 5, "R8", "dropped group not sent", frames_seen, 5);
    check(overrun, "R8", "overrun sticky", int'(overrun), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule